// File: doc/BRIEF.md
# Channel Status, User and Validity Bit Source for a Digital Audio Transmitter

This block supplies the three per-subframe side bits that a two-channel digital audio transmitter (AES3 style) carries with every sample: channel status (C), user (U) and validity (V). A frame clock runs at the frame rate. Its high phase is the left subframe and its low phase is the right subframe. The block detects each change of level on that clock in the system clock domain. One system clock later it presents a fresh C/U/V set together with a one-cycle valid pulse.

A mode input selects where C comes from. With the mode input low, the block builds a 192-frame channel status block itself from a few static pins: copy, originality, emphasis and a non-audio flag. With the mode input high, C is taken serially from the shared copy/C pin, one bit per subframe, as U and V always are. The block keeps track of the frame position inside the 192-frame block. A block-start strobe either reports frame 0 as an output or, as an input, forces the position back to frame 0.

Top module: `cuv_source`

## Requirements
- R1: While reset is held and after its release, before any frame-clock edge, `c_out`, `u_out`, `v_out`, `bit_valid`, `blk_strobe_out` and `frame_index` are all 0.
- R2: After each change of level on `frame_clk`, `bit_valid` is high for exactly one system clock. This happens at the second rising `clk` edge after the change is first sampled, and the C/U/V outputs take their new values at that same edge.
- R3: `u_out` and `v_out` carry the values that `u_in` and `v_in` had when the frame-clock change was sampled. This gives one bit per subframe on both the rising (left) and falling (right) edges, in either mode.
- R4: With `serial_mode` low, `c_out` is bit N of the internally built block, where N is the frame position. The same value is shown for the left and the right subframe of a frame.
- R5: The two-bit pair {copy, originality} selects the fields: 00 gives consumer format with copy bit 0 and generation bit 0; 01 gives consumer format with copy 0 and generation 1; 10 gives consumer format with copy 1 and generation 0; 11 gives professional format.
- R6: In consumer format, bit 0 is 0, bit 1 is the non-audio flag, bit 2 is the copy bit, and bit 3 is 1 when emphasis is on (bits 4 and 5 are 0). Bits 8 to 14, bit 8 first, carry the category code 0,1,0,1,1,0,0. Bit 15 is the generation bit and every other bit is 0.
- R7: In professional format, bit 0 is 1, bit 1 is the non-audio flag, bit 2 is 1, bit 3 is 1 when emphasis is on, and all bits from 4 to 191 are 0.
- R8: With `serial_mode` high, `c_out` is the value of `copy_c_in` sampled at the frame-clock change, for each subframe on its own.
- R9: The frame position advances on each rising `frame_clk` edge, and `frame_index` shows the position of the frame being presented. The first frame after reset is frame 0, and frame 191 is followed by frame 0.
- R10: With `strobe_dir_out` high, `blk_strobe_oe` is 1 and `blk_strobe_out` is high for the whole of frame 0 (both subframes) and low for every other frame.
- R11: With `strobe_dir_out` low, `blk_strobe_oe` and `blk_strobe_out` are 0. A high `blk_strobe_in` sampled with a rising frame-clock edge makes that frame frame 0, and later frames count on from there.
- R12: The copy, originality, emphasis and non-audio pins are captured only at the start of frame 0. A change on them during a block has no effect on `c_out` until the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock, high = left subframe |
| serial_mode | input | 1 | 0 = internal C block, 1 = serial C |
| copy_c_in | input | 1 | Copy pin (internal mode) or serial C bit (serial mode) |
| orig_in | input | 1 | Originality pin |
| emph_in | input | 1 | Emphasis on |
| nonaudio_in | input | 1 | Non-audio flag |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| strobe_dir_out | input | 1 | 1 = block strobe is an output |
| blk_strobe_in | input | 1 | External block-start strobe |
| blk_strobe_out | output | 1 | Block-start strobe driven out |
| blk_strobe_oe | output | 1 | Output enable for the strobe |
| c_out | output | 1 | Channel status bit |
| u_out | output | 1 | User bit |
| v_out | output | 1 | Validity bit |
| bit_valid | output | 1 | One-cycle pulse: new C/U/V presented |
| frame_index | output | 8 | Frame position in the block |

## Verification
A frame counter that is off by one or wraps at the wrong count shows at the ports in two ways. The category and generation bits of `c_out` land in the wrong frames within 16 frames of block start, and the strobe and `frame_index` disagree with the bench's own count at the next wrap. A configuration latch that tracks the pins all the time instead of holding shows in the first C bit after a mid-block pin change. A wrong edge detector shows as a missing or misplaced `bit_valid` pulse on the very next subframe. Every subframe is compared against a bench model of the block, so each of these faults is reported within one block at most.

// File: rtl/cuv_pkg.sv
package cuv_pkg;

    typedef struct packed {
        logic pro;
        logic copy;
        logic gen_l;
        logic emph;
        logic nonaudio;
    } cs_cfg_t;

    // category code, LSB lands on channel status bit 8
    localparam logic [6:0] CAT_RATE_CONV = 7'b0011010;

    function automatic cs_cfg_t decode_cfg(logic copy, logic orig, logic emph, logic na);
        cs_cfg_t c;
        c.pro      = copy & orig;
        c.copy     = copy & ~orig;
        c.gen_l    = ~copy & orig;
        c.emph     = emph;
        c.nonaudio = na;
        return c;
    endfunction

    // first 16 channel status bits; all later bits are zero
    function automatic logic [15:0] cs_head(cs_cfg_t c);
        logic [15:0] w;
        w = '0;
        w[1] = c.nonaudio;
        w[3] = c.emph;
        if (c.pro) begin
            w[0] = 1'b1;
            w[2] = 1'b1;
        end else begin
            w[2]    = c.copy;
            w[14:8] = CAT_RATE_CONV;
            w[15]   = c.gen_l;
        end
        return w;
    endfunction

endpackage

// File: rtl/cuv_edge_stage.sv
module cuv_edge_stage #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic [NBITS-1:0] bits_in,
    output logic             rise,
    output logic             fall,
    output logic [NBITS-1:0] bits_stage
);
    typedef struct packed {
        logic             lr;
        logic             lr_prev;
        logic [NBITS-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.lr      = frame_clk;
        st_d.lr_prev = st_q.lr;
        st_d.bits    = bits_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise       = st_q.lr & ~st_q.lr_prev;
    assign fall       = ~st_q.lr & st_q.lr_prev;
    assign bits_stage = st_q.bits;

endmodule

// File: rtl/cuv_frame_counter.sv
module cuv_frame_counter #(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             resync,
    output logic [IDX_W-1:0] cur_frame,
    output logic             at_start
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign cur_frame = resync ? '0 : st_q.cnt;
    assign at_start  = (cur_frame == '0);

    always_comb begin
        st_d = st_q;
        if (rise) begin
            st_d.cnt = (cur_frame == LAST) ? '0 : cur_frame + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    p_resync_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && resync) |=> (st_q.cnt == IDX_W'(1)));

endmodule

// File: rtl/cuv_cs_gen.sv
module cuv_cs_gen
    import cuv_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             at_start,
    input  logic [IDX_W-1:0] cur_frame,
    input  logic             copy_pin,
    input  logic             orig_pin,
    input  logic             emph_pin,
    input  logic             na_pin,
    output logic             cs_bit
);
    typedef struct packed {
        cs_cfg_t cfg;
    } st_t;

    st_t         st_d, st_q;
    cs_cfg_t     pin_cfg, use_cfg;
    logic [15:0] head;

    always_comb begin
        pin_cfg = decode_cfg(copy_pin, orig_pin, emph_pin, na_pin);
        use_cfg = at_start ? pin_cfg : st_q.cfg;
        head    = cs_head(use_cfg);
        cs_bit  = (cur_frame < IDX_W'(16)) ? head[cur_frame[3:0]] : 1'b0;
        st_d    = st_q;
        if (rise && at_start) st_d.cfg = pin_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && at_start) |=> $stable(st_q.cfg));

endmodule

// File: rtl/cuv_source.sv
module cuv_source #(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic             serial_mode,
    input  logic             copy_c_in,
    input  logic             orig_in,
    input  logic             emph_in,
    input  logic             nonaudio_in,
    input  logic             u_in,
    input  logic             v_in,
    input  logic             strobe_dir_out,
    input  logic             blk_strobe_in,
    output logic             blk_strobe_out,
    output logic             blk_strobe_oe,
    output logic             c_out,
    output logic             u_out,
    output logic             v_out,
    output logic             bit_valid,
    output logic [IDX_W-1:0] frame_index
);
    localparam int NB = 8;
    localparam int B_V = 0, B_U = 1, B_C = 2, B_OR = 3, B_EM = 4, B_NA = 5, B_SB = 6, B_MD = 7;

    logic             rise, fall, resync, at_start, cs_bit;
    logic [NB-1:0]    stg;
    logic [IDX_W-1:0] cur_frame;

    cuv_edge_stage #(.NBITS(NB)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .bits_in    ({serial_mode, blk_strobe_in, nonaudio_in, emph_in,
                      orig_in, copy_c_in, u_in, v_in}),
        .rise       (rise),
        .fall       (fall),
        .bits_stage (stg)
    );

    assign resync = rise & ~strobe_dir_out & stg[B_SB];

    cuv_frame_counter #(.FRAMES(FRAMES)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .resync    (resync),
        .cur_frame (cur_frame),
        .at_start  (at_start)
    );

    cuv_cs_gen #(.FRAMES(FRAMES)) u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .at_start  (at_start),
        .cur_frame (cur_frame),
        .copy_pin  (stg[B_C]),
        .orig_pin  (stg[B_OR]),
        .emph_pin  (stg[B_EM]),
        .na_pin    (stg[B_NA]),
        .cs_bit    (cs_bit)
    );

    typedef struct packed {
        logic             c;
        logic             u;
        logic             v;
        logic             valid;
        logic             left;
        logic             serial;
        logic             strobe;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rise || fall) begin
            st_d.valid  = 1'b1;
            st_d.left   = rise;
            st_d.serial = stg[B_MD];
            st_d.u      = stg[B_U];
            st_d.v      = stg[B_V];
            if (stg[B_MD])  st_d.c = stg[B_C];
            else if (rise)  st_d.c = cs_bit;
            if (rise) begin
                st_d.idx    = cur_frame;
                st_d.strobe = at_start;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_out          = st_q.c;
    assign u_out          = st_q.u;
    assign v_out          = st_q.v;
    assign bit_valid      = st_q.valid;
    assign frame_index    = st_q.idx;
    assign blk_strobe_oe  = strobe_dir_out;
    assign blk_strobe_out = st_q.strobe & strobe_dir_out;

    p_c_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !st_q.left && !st_q.serial) |-> $stable(st_q.c));

    p_strobe_frame0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_strobe_out |-> (frame_index == '0));

endmodule

// File: tb/cuv_source_test.sv
module cuv_source_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clk = 1'b0, serial_mode = 1'b0, copy_c_in = 1'b0, orig_in = 1'b0;
    logic emph_in = 1'b0, nonaudio_in = 1'b0, u_in = 1'b0, v_in = 1'b0;
    logic strobe_dir_out = 1'b1, blk_strobe_in = 1'b0;
    logic blk_strobe_out, blk_strobe_oe, c_out, u_out, v_out, bit_valid;
    logic [7:0] frame_index;

    int checks = 0, failures = 0, seq = 0, exp_idx = 0;
    logic pin_copy = 1'b0, lat_cp = 1'b0, lat_og = 1'b0, lat_em = 1'b0, lat_na = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cuv_source uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_cs(int idx, logic cp, logic og, logic em, logic na);
        logic [6:0] cat = 7'b0101100;
        if (cp && og) begin
            if (idx == 0 || idx == 2) return 1'b1;
            if (idx == 1) return na;
            if (idx == 3) return em;
            return 1'b0;
        end
        if (idx == 1) return na;
        if (idx == 2) return cp & ~og;
        if (idx == 3) return em;
        if (idx >= 8 && idx <= 14) return cat[14 - idx];
        if (idx == 15) return ~cp & og;
        return 1'b0;
    endfunction

    task automatic send_sub(input logic lvl, input logic c, input logic u, input logic v, input logic s);
        @(negedge clk);
        frame_clk = lvl; copy_c_in = c; u_in = u; v_in = v; blk_strobe_in = s;
        @(posedge clk); @(posedge clk); @(negedge clk);
        #1;
    endtask

    task automatic run_frame(input string ctag, input logic resync);
        logic cl, cr, ul, ur, vl, vr, ec_l, ec_r;
        seq++;
        ul = seq[0] ^ seq[3]; ur = seq[1]; vl = seq[2]; vr = ~seq[0];
        cl = serial_mode ? (seq[1] ^ seq[2]) : pin_copy;
        cr = serial_mode ? ~seq[0] : pin_copy;
        if (resync) exp_idx = 0;
        if (exp_idx == 0) begin
            lat_cp = cl; lat_og = orig_in; lat_em = emph_in; lat_na = nonaudio_in;
        end
        ec_l = serial_mode ? cl : exp_cs(exp_idx, lat_cp, lat_og, lat_em, lat_na);
        ec_r = serial_mode ? cr : ec_l;
        send_sub(1'b1, cl, ul, vl, resync);
        chk("R2 valid left", bit_valid, 1);
        chk("R3 u left", u_out, ul);
        chk("R3 v left", v_out, vl);
        chk({ctag, " c left"}, c_out, ec_l);
        chk("R9 index", frame_index, exp_idx);
        if (strobe_dir_out) chk("R10 strobe", blk_strobe_out, exp_idx == 0);
        else                chk("R11 strobe off", blk_strobe_out, 0);
        chk("R10 R11 oe", blk_strobe_oe, strobe_dir_out);
        send_sub(1'b0, cr, ur, vr, 1'b0);
        chk("R2 valid right", bit_valid, 1);
        chk("R3 u right", u_out, ur);
        chk("R3 v right", v_out, vr);
        chk({ctag, " c right"}, c_out, ec_r);
        if (strobe_dir_out) chk("R10 strobe right", blk_strobe_out, exp_idx == 0);
        @(posedge clk); #1;
        chk("R2 pulse width", bit_valid, 0);
        exp_idx = (exp_idx == 191) ? 0 : exp_idx + 1;
    endtask

    task automatic set_pins(input logic cp, input logic og, input logic em, input logic na);
        @(negedge clk);
        pin_copy = cp; copy_c_in = cp; orig_in = og; emph_in = em; nonaudio_in = na;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 c", c_out, 0); chk("R1 u", u_out, 0); chk("R1 v", v_out, 0);
        chk("R1 valid", bit_valid, 0); chk("R1 idx", frame_index, 0);
        chk("R1 strobe", blk_strobe_out, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid after", bit_valid, 0); chk("R1 c after", c_out, 0);
    endtask

    task automatic t_consumer_block;
        set_pins(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 192; i++) run_frame("R4 R6", 1'b0);
        run_frame("R9 wrap", 1'b0);
        for (int i = 1; i < 192; i++) run_frame("R4", 1'b0);
    endtask

    task automatic t_encodings;
        set_pins(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 192; i++) run_frame("R5 R6 gen", 1'b0);
        set_pins(1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 192; i++) run_frame("R5 R6 copy", 1'b0);
        set_pins(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 192; i++) run_frame("R5 R7 pro", 1'b0);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 192; i++) run_frame("R7 pro", 1'b0);
    endtask

    task automatic t_midblock;
        set_pins(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) run_frame("R12", 1'b0);
        set_pins(1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 5; i < 192; i++) run_frame("R12", 1'b0);
        for (int i = 0; i < 20; i++) run_frame("R12 next", 1'b0);
    endtask

    task automatic t_serial;
        @(negedge clk); serial_mode = 1'b1;
        for (int i = 0; i < 24; i++) run_frame("R8", 1'b0);
        @(negedge clk); serial_mode = 1'b0;
    endtask

    task automatic t_strobe_in;
        @(negedge clk); strobe_dir_out = 1'b0;
        set_pins(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) run_frame("R11 pre", 1'b0);
        run_frame("R11 resync", 1'b1);
        for (int i = 0; i < 20; i++) run_frame("R11 post", 1'b0);
        run_frame("R11 resync again", 1'b1);
        for (int i = 0; i < 16; i++) run_frame("R11", 1'b0);
    endtask

    initial begin
        t_reset();
        t_consumer_block();
        t_encodings();
        t_midblock();
        t_serial();
        t_strobe_in();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule